// File: doc/BRIEF.md
# Multi-Bank Ternary Match Table

This block is a ternary match table for packet classification. Storage is split into four banks of equal depth. One row of a bank holds a 112-bit slice of the search key: a 64-bit low word plus a 48-bit high word. Each stored bit is a pair of flags. One flag means "must be one" and the other means "must be zero". When both flags are clear, the bit matches any key value. A configurable key mode joins one, two or four neighbouring banks into a single logical entry. Wider keys therefore leave fewer logical entries.

Software fills the table through a write port. Each write names a logical entry index, a part (which bank of that entry) and an operation. The bank and row to touch follow from the index and the current key mode. Each bank row also stores a 2-bit interface tag and an enable flag. The first bank of an entry stores a 64-bit action and a 64-bit tag action. A lookup presents a key and an interface number. Two cycles later the block returns the lowest-numbered entry that matches, with its actions. If nothing matches, it returns the miss action held for that interface.

Top module: `tcam_match`

## Requirements
- R1: A word write stores, for each bit, "must be one" = data AND mask and "must be zero" = NOT data AND mask. A key bit mismatches only when its "must be one" flag is set and the key bit is 0, or its "must be zero" flag is set and the key bit is 1. A masked-out bit matches anything. Write operation codes: 0 low word (64 bits), 1 high word, 2 interface tag, 3 enable, 4 action, 5 tag action, 6 miss action.
- R2: A high-word write keeps only bits 47:0 of data and mask. These bits are compared against key bits 111:64 of the slice. Data bits 63:48 of that write have no effect.
- R3: Key mode 0 uses 1 bank per entry, mode 1 uses 2, and modes 2 and 3 use 4. The entry count is (banks / span) × depth. Entry i uses row i mod depth and starts at bank (i div depth) × span. Part p of an entry is compared with key slice p, which is lk_key bits p×112 upward. A hit never reports an index at or beyond the entry count. Writes to such an index are ignored.
- R4: Each bank row carries a 2-bit interface tag. A tag write sets the row to match exactly that interface. An entry hits only if every one of its banks accepts the lookup interface.
- R5: An enable write (data bit 0) sets or clears the enable flag in every bank the entry spans. An entry hits only when all of its banks are enabled.
- R6: When several entries hit, the lowest logical index is reported.
- R7: Action and tag action are stored once per entry, at its first bank and row. They are returned on a hit.
- R8: On a miss, res_action is the miss action of the lookup interface and res_tag_action is zero. After reset, interface 1 holds 64'h1 (transmit default unicast) and all other interfaces hold 64'h0 (receive drop). A miss-action write sets interface wr_index[1:0].
- R9: A lookup accepted with lk_valid in cycle t gives res_valid in cycle t+2 only. res_hit is low whenever res_valid is low. The result data hold their value between results.
- R10: After reset no entry is enabled, res_valid and res_hit are low, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_mode | input | 2 | Banks per entry: 0 one, 1 two, 2/3 four |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | Write operation code |
| wr_index | input | IW | Logical entry index, or interface number for miss writes |
| wr_part | input | 2 | Bank of the entry for word and tag writes |
| wr_data | input | 64 | Write data |
| wr_mask | input | 64 | Care mask for word writes |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | NB*112 | Search key, slice p at bits p*112 |
| lk_intf | input | 2 | Lookup interface number |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | An entry matched |
| res_index | output | IW | Winning logical index |
| res_action | output | 64 | Entry action or miss action |
| res_tag_action | output | 64 | Entry tag action, zero on a miss |

## Verification
The hardest condition to reach from the ports is an entry that agrees on everything except one bank's tag or enable flag. Only a bank-level difference separates a correct design from one that checks only the first bank. The bench builds such an entry by writing parts one at a time in two-bank mode, with a lower-numbered entry whose second-bank tag disagrees. It then switches a four-bank entry back to one-bank mode. The far bank must then hit by itself, which proves that the enable write reached every spanned bank and that the action is held only at the first bank.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int SLICE_W0 = 64;
  localparam int SLICE_W1 = 48;
  localparam int SLICE_W  = SLICE_W0 + SLICE_W1;
  localparam int ACT_W    = 64;
  localparam int TAG_W    = 2;
  localparam int N_INTF   = 1 << TAG_W;
  localparam logic [ACT_W-1:0] MISS_DROP     = 64'h0;
  localparam logic [ACT_W-1:0] MISS_UC_DFLT  = 64'h1;
  localparam int TX_INTF  = 1;

  typedef enum logic [2:0] {
    OP_WORD0   = 3'd0,
    OP_WORD1   = 3'd1,
    OP_TAG     = 3'd2,
    OP_ENABLE  = 3'd3,
    OP_ACTION  = 3'd4,
    OP_TACTION = 3'd5,
    OP_MISS    = 3'd6
  } tcam_op_e;

  // log2 of banks joined per entry
  function automatic logic [1:0] span_shift(input logic [1:0] mode);
    case (mode)
      2'd0:    span_shift = 2'd0;
      2'd1:    span_shift = 2'd1;
      default: span_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/tcam_bank.sv
module tcam_bank
  import tcam_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int RW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  tcam_op_e           wr_op,
  input  logic [RW-1:0]      wr_row,
  input  logic [63:0]        wr_data,
  input  logic [63:0]        wr_mask,
  input  logic [SLICE_W-1:0] key,
  input  logic [TAG_W-1:0]   intf,
  output logic [DEPTH-1:0]   row_match
);
  logic [SLICE_W-1:0] one_q [DEPTH];
  logic [SLICE_W-1:0] one_d [DEPTH];
  logic [SLICE_W-1:0] zero_q[DEPTH];
  logic [SLICE_W-1:0] zero_d[DEPTH];
  logic [TAG_W-1:0]   tone_q[DEPTH];
  logic [TAG_W-1:0]   tone_d[DEPTH];
  logic [TAG_W-1:0]   tzero_q[DEPTH];
  logic [TAG_W-1:0]   tzero_d[DEPTH];
  logic [DEPTH-1:0]   en_q, en_d;
  logic [63:0]        set_bits, clr_bits;

  assign set_bits = wr_data & wr_mask;
  assign clr_bits = ~wr_data & wr_mask;

  always_comb begin
    one_d   = one_q;
    zero_d  = zero_q;
    tone_d  = tone_q;
    tzero_d = tzero_q;
    en_d    = en_q;
    if (wr_en) begin
      case (wr_op)
        OP_WORD0: begin
          one_d[wr_row][SLICE_W0-1:0]  = set_bits;
          zero_d[wr_row][SLICE_W0-1:0] = clr_bits;
        end
        OP_WORD1: begin
          one_d[wr_row][SLICE_W-1:SLICE_W0]  = set_bits[SLICE_W1-1:0];
          zero_d[wr_row][SLICE_W-1:SLICE_W0] = clr_bits[SLICE_W1-1:0];
        end
        OP_TAG: begin
          tone_d[wr_row]  = wr_data[TAG_W-1:0];
          tzero_d[wr_row] = ~wr_data[TAG_W-1:0];
        end
        OP_ENABLE: en_d[wr_row] = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) begin
        one_q[r]   <= '0;
        zero_q[r]  <= '0;
        tone_q[r]  <= '0;
        tzero_q[r] <= '0;
      end
      en_q <= '0;
    end else if (wr_en) begin
      one_q   <= one_d;
      zero_q  <= zero_d;
      tone_q  <= tone_d;
      tzero_q <= tzero_d;
      en_q    <= en_d;
    end
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    assign row_match[r] = en_q[r]
                        & ~|((one_q[r] & ~key) | (zero_q[r] & key))
                        & ~|((tone_q[r] & ~intf) | (tzero_q[r] & intf));
  end
endmodule

// File: rtl/tcam_resolve.sv
module tcam_resolve #(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  localparam int NE = NB * DEPTH,
  localparam int IW = $clog2(NE)
) (
  input  logic [1:0]    shift,
  input  logic [NE-1:0] bank_match,
  output logic          any_hit,
  output logic [IW-1:0] hit_index
);
  logic [NE-1:0] ent_hit;

  for (genvar i = 0; i < NE; i++) begin : g_ent
    localparam int G = i / DEPTH;
    localparam int R = i % DEPTH;
    logic h1, h2, h4;
    assign h1 = bank_match[G*DEPTH+R];
    if (2*G+1 < NB) begin : g_x2
      assign h2 = bank_match[(2*G)*DEPTH+R] & bank_match[(2*G+1)*DEPTH+R];
    end else begin : g_nx2
      assign h2 = 1'b0;
    end
    if (4*G+3 < NB) begin : g_x4
      assign h4 = bank_match[(4*G)*DEPTH+R]   & bank_match[(4*G+1)*DEPTH+R]
                & bank_match[(4*G+2)*DEPTH+R] & bank_match[(4*G+3)*DEPTH+R];
    end else begin : g_nx4
      assign h4 = 1'b0;
    end
    assign ent_hit[i] = (shift == 2'd0) ? h1 : (shift == 2'd1) ? h2 : h4;
  end

  always_comb begin
    any_hit   = |ent_hit;
    hit_index = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (ent_hit[i]) hit_index = IW'(i);
    end
  end
endmodule

// File: rtl/tcam_match.sv
module tcam_match
  import tcam_pkg::*;
#(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  localparam int BW = $clog2(NB),
  localparam int RW = $clog2(DEPTH),
  localparam int IW = BW + RW,
  localparam int NE = NB * DEPTH,
  localparam int KW = NB * SLICE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       key_mode,
  input  logic             wr_en,
  input  logic [2:0]       wr_op,
  input  logic [IW-1:0]    wr_index,
  input  logic [1:0]       wr_part,
  input  logic [63:0]      wr_data,
  input  logic [63:0]      wr_mask,
  input  logic             lk_valid,
  input  logic [KW-1:0]    lk_key,
  input  logic [TAG_W-1:0] lk_intf,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IW-1:0]    res_index,
  output logic [ACT_W-1:0] res_action,
  output logic [ACT_W-1:0] res_tag_action
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  tcam_op_e      op;
  logic [1:0]    shift;
  logic [1:0]    span_mask;
  logic [BW-1:0] w_grp, w_base, w_phys;
  logic          w_in_range, w_part_ok;
  logic [IW-1:0] w_pos;
  logic [NB-1:0] bank_we;

  assign op         = tcam_op_e'(wr_op);
  assign shift      = span_shift(key_mode);
  assign span_mask  = 2'((1 << shift) - 1);
  assign w_grp      = wr_index[IW-1:RW];
  assign w_base     = w_grp << shift;
  assign w_phys     = w_base + BW'(wr_part);
  assign w_in_range = (int'(w_grp) << shift) < NB;
  assign w_part_ok  = int'(wr_part) < (1 << shift);
  assign w_pos      = {w_base, wr_index[RW-1:0]};

  // lookup stage 1
  logic             s1_valid;
  logic [KW-1:0]    s1_key;
  logic [TAG_W-1:0] s1_intf;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_valid <= 1'b0;
      s1_key   <= '0;
      s1_intf  <= '0;
    end else begin
      s1_valid <= lk_valid;
      if (lk_valid) begin
        s1_key  <= lk_key;
        s1_intf <= lk_intf;
      end
    end
  end

  logic [NE-1:0] bank_match;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic               span_hit;
    logic [1:0]         sl;
    logic [SLICE_W-1:0] b_key;
    assign span_hit = (b >= int'(w_base)) && (b < int'(w_base) + (1 << shift));
    assign bank_we[b] = wr_en && w_in_range &&
                        ((op == OP_ENABLE) ? span_hit :
                         ((op == OP_WORD0 || op == OP_WORD1 || op == OP_TAG) &&
                          w_part_ok && (w_phys == BW'(b))));
    assign sl    = 2'(b) & span_mask;
    assign b_key = s1_key[sl*SLICE_W +: SLICE_W];

    tcam_bank #(.DEPTH(DEPTH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .wr_en     (bank_we[b]),
      .wr_op     (op),
      .wr_row    (wr_index[RW-1:0]),
      .wr_data   (wr_data),
      .wr_mask   (wr_mask),
      .key       (b_key),
      .intf      (s1_intf),
      .row_match (bank_match[b*DEPTH +: DEPTH])
    );
  end

  logic          r_hit;
  logic [IW-1:0] r_idx;

  tcam_resolve #(.NB(NB), .DEPTH(DEPTH)) u_resolve (
    .shift      (shift),
    .bank_match (bank_match),
    .any_hit    (r_hit),
    .hit_index  (r_idx)
  );

  // action storage at each entry's first bank; miss action per interface
  logic [ACT_W-1:0] act_q  [NE];
  logic [ACT_W-1:0] act_d  [NE];
  logic [ACT_W-1:0] tact_q [NE];
  logic [ACT_W-1:0] tact_d [NE];
  logic [ACT_W-1:0] miss_q [N_INTF];
  logic [ACT_W-1:0] miss_d [N_INTF];

  always_comb begin
    act_d  = act_q;
    tact_d = tact_q;
    miss_d = miss_q;
    if (wr_en && w_in_range && op == OP_ACTION)  act_d[w_pos]  = wr_data;
    if (wr_en && w_in_range && op == OP_TACTION) tact_d[w_pos] = wr_data;
    if (wr_en && op == OP_MISS) miss_d[wr_index[TAG_W-1:0]] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int e = 0; e < NE; e++) begin
        act_q[e]  <= '0;
        tact_q[e] <= '0;
      end
      for (int f = 0; f < N_INTF; f++) begin
        miss_q[f] <= (f == TX_INTF) ? MISS_UC_DFLT : MISS_DROP;
      end
    end else if (wr_en) begin
      act_q  <= act_d;
      tact_q <= tact_d;
      miss_q <= miss_d;
    end
  end

  // lookup stage 2: result registers
  logic [BW-1:0]    r_base;
  logic [IW-1:0]    r_pos;
  logic [ACT_W-1:0] res_action_d, res_tag_action_d;

  assign r_base = r_idx[IW-1:RW] << shift;
  assign r_pos  = {r_base, r_idx[RW-1:0]};

  always_comb begin
    res_action_d     = r_hit ? act_q[r_pos]  : miss_q[s1_intf];
    res_tag_action_d = r_hit ? tact_q[r_pos] : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_valid      <= 1'b0;
      res_hit        <= 1'b0;
      res_index      <= '0;
      res_action     <= '0;
      res_tag_action <= '0;
    end else begin
      res_valid <= s1_valid;
      res_hit   <= s1_valid & r_hit;
      if (s1_valid) begin
        res_index      <= r_hit ? r_idx : '0;
        res_action     <= res_action_d;
        res_tag_action <= res_tag_action_d;
      end
    end
  end
endmodule

// File: rtl/tcam_match_checks.sv
module tcam_match_checks
  import tcam_pkg::*;
#(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  localparam int IW = $clog2(NB * DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       key_mode,
  input logic             lk_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IW-1:0]    res_index,
  input logic [ACT_W-1:0] res_action
);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ##1 res_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ##1 !res_valid);

  assert_hit_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_action));

  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |->
      (int'(res_index) < ((NB >> span_shift(key_mode)) * DEPTH)));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_R10: assert (!res_valid && !res_hit);
  end
endmodule

bind tcam_match tcam_match_checks #(.NB(NB), .DEPTH(DEPTH)) u_checks (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .key_mode   (key_mode),
  .lk_valid   (lk_valid),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_index  (res_index),
  .res_action (res_action)
);

// File: tb/tcam_match_tb.sv
module tcam_match_tb;
  localparam int KW = 448;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    key_mode;
  logic          wr_en;
  logic [2:0]    wr_op;
  logic [3:0]    wr_index;
  logic [1:0]    wr_part;
  logic [63:0]   wr_data, wr_mask;
  logic          lk_valid;
  logic [KW-1:0] lk_key;
  logic [1:0]    lk_intf;
  logic          res_valid, res_hit;
  logic [3:0]    res_index;
  logic [63:0]   res_action, res_tag_action;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tcam_match u_dut (
    .clk(clk), .rst_n(rst_n), .key_mode(key_mode),
    .wr_en(wr_en), .wr_op(wr_op), .wr_index(wr_index), .wr_part(wr_part),
    .wr_data(wr_data), .wr_mask(wr_mask),
    .lk_valid(lk_valid), .lk_key(lk_key), .lk_intf(lk_intf),
    .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
    .res_action(res_action), .res_tag_action(res_tag_action)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] put(input logic [KW-1:0] k, input int s,
                                        input logic [63:0] w0, input logic [47:0] w1);
    logic [KW-1:0] r;
    r = k;
    r[s*112 +: 64]    = w0;
    r[s*112+64 +: 48] = w1;
    return r;
  endfunction

  task automatic wr(input logic [2:0] op, input int idx, input int part,
                    input logic [63:0] d, input logic [63:0] m);
    wr_en = 1'b1; wr_op = op; wr_index = 4'(idx); wr_part = 2'(part);
    wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [KW-1:0] k, input logic [1:0] intf, input bit eh,
                        input int ei, input logic [63:0] ea, input logic [63:0] et,
                        input string req);
    lk_valid = 1'b1; lk_key = k; lk_intf = intf;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid == 1'b0, {req, " R9 early"}, 64'(res_valid), 64'd0);
    @(negedge clk);
    chk(res_valid == 1'b1, {req, " R9 valid"}, 64'(res_valid), 64'd1);
    chk(res_hit == eh, {req, " hit"}, 64'(res_hit), 64'(eh));
    if (eh) chk(res_index == 4'(ei), {req, " index"}, 64'(res_index), 64'(ei));
    chk(res_action == ea, {req, " action"}, res_action, ea);
    chk(res_tag_action == et, {req, " tag action"}, res_tag_action, et);
    @(negedge clk);
    chk(res_valid == 1'b0, {req, " R9 one-shot"}, 64'(res_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk(res_valid == 1'b0 && res_hit == 1'b0, "R10 outputs idle", 64'(res_valid), 64'd0);
    lookup('0, 2'd0, 1'b0, 0, 64'h0, 64'h0, "R10 R8 rx drop");
    lookup('0, 2'd1, 1'b0, 0, 64'h1, 64'h0, "R8 tx default");
  endtask

  task automatic t_x1_basic();
    key_mode = 2'd0;
    wr(3'd0, 5, 0, 64'hAB, 64'hFF);
    wr(3'd1, 5, 0, 64'hFFFF_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd2, 5, 0, 64'h0, 64'h0);
    wr(3'd4, 5, 0, 64'hA5A5, 64'h0);
    wr(3'd5, 5, 0, 64'h5A, 64'h0);
    wr(3'd3, 5, 0, 64'h1, 64'h0);
    lookup(put('0, 0, 64'h1234_00AB, 48'h1), 2'd0, 1'b1, 5, 64'hA5A5, 64'h5A, "R1 R2 R7 hit");
    lookup(put('0, 0, 64'hAA, 48'h1), 2'd0, 1'b0, 0, 64'h0, 64'h0, "R1 low word miss");
    lookup(put('0, 0, 64'hAB, 48'h3), 2'd0, 1'b0, 0, 64'h0, 64'h0, "R2 high word miss");
    lookup(put('0, 0, 64'hAB, 48'h1), 2'd1, 1'b0, 0, 64'h1, 64'h0, "R4 wrong intf");
    wr(3'd3, 5, 0, 64'h0, 64'h0);
    lookup(put('0, 0, 64'hAB, 48'h1), 2'd0, 1'b0, 0, 64'h0, 64'h0, "R5 disabled");
  endtask

  task automatic t_priority();
    wr(3'd4, 3, 0, 64'h33, 64'h0);
    wr(3'd4, 9, 0, 64'h99, 64'h0);
    wr(3'd3, 9, 0, 64'h1, 64'h0);
    wr(3'd3, 3, 0, 64'h1, 64'h0);
    lookup(put('0, 0, 64'h77, 48'h5), 2'd2, 1'b1, 3, 64'h33, 64'h0, "R6 lowest wins");
    wr(3'd3, 3, 0, 64'h0, 64'h0);
    lookup(put('0, 0, 64'h77, 48'h5), 2'd2, 1'b1, 9, 64'h99, 64'h0, "R6 next wins");
    wr(3'd3, 9, 0, 64'h0, 64'h0);
  endtask

  task automatic t_x2();
    logic [KW-1:0] k;
    key_mode = 2'd1;
    wr(3'd0, 6, 0, 64'h11, 64'hFF);
    wr(3'd0, 6, 1, 64'h22, 64'hFF);
    wr(3'd2, 6, 0, 64'h1, 64'h0);
    wr(3'd2, 6, 1, 64'h1, 64'h0);
    wr(3'd4, 6, 0, 64'h66, 64'h0);
    wr(3'd5, 6, 0, 64'h6, 64'h0);
    wr(3'd3, 6, 0, 64'h1, 64'h0);
    k = put(put('0, 0, 64'h11, 48'h0), 1, 64'h22, 48'h0);
    lookup(k, 2'd1, 1'b1, 6, 64'h66, 64'h6, "R3 two-bank hit");
    lookup(put(k, 1, 64'h23, 48'h0), 2'd1, 1'b0, 0, 64'h1, 64'h0, "R3 second slice miss");
    wr(3'd2, 0, 0, 64'h1, 64'h0);
    wr(3'd2, 0, 1, 64'h0, 64'h0);
    wr(3'd4, 0, 0, 64'h0F, 64'h0);
    wr(3'd3, 0, 0, 64'h1, 64'h0);
    lookup(k, 2'd1, 1'b1, 6, 64'h66, 64'h6, "R4 second bank tag");
    wr(3'd2, 0, 1, 64'h1, 64'h0);
    lookup(k, 2'd1, 1'b1, 0, 64'h0F, 64'h0, "R4 R6 both tags");
    wr(3'd3, 0, 0, 64'h0, 64'h0);
    wr(3'd3, 6, 0, 64'h0, 64'h0);
    lookup(k, 2'd1, 1'b0, 0, 64'h1, 64'h0, "R5 two-bank disable");
  endtask

  task automatic t_x4();
    logic [KW-1:0] k;
    key_mode = 2'd2;
    k = '0;
    for (int p = 0; p < 4; p++) begin
      wr(3'd0, 3, p, 64'(8'h40 + p), 64'hFF);
      wr(3'd2, 3, p, 64'h2, 64'h0);
      k = put(k, p, 64'(8'h40 + p), 48'h0);
    end
    wr(3'd4, 3, 0, 64'h4444, 64'h0);
    wr(3'd5, 3, 0, 64'h44, 64'h0);
    wr(3'd3, 3, 0, 64'h1, 64'h0);
    lookup(k, 2'd2, 1'b1, 3, 64'h4444, 64'h44, "R3 R7 four-bank hit");
    lookup(put(k, 3, 64'h0, 48'h0), 2'd2, 1'b0, 0, 64'h0, 64'h0, "R3 R8 last slice miss");
    key_mode = 2'd0;
    lookup(put('0, 0, 64'h43, 48'h0), 2'd2, 1'b1, 15, 64'h0, 64'h0, "R5 R7 far bank enabled");
  endtask

  task automatic t_miss_write();
    key_mode = 2'd0;
    wr(3'd6, 0, 0, 64'hDEAD, 64'h0);
    lookup('0, 2'd0, 1'b0, 0, 64'hDEAD, 64'h0, "R8 rx miss written");
    lookup('0, 2'd3, 1'b0, 0, 64'h0, 64'h0, "R8 intf3 drop");
    lookup('0, 2'd1, 1'b0, 0, 64'h1, 64'h0, "R8 tx untouched");
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog R9 actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; key_mode = 2'd0; wr_en = 1'b0; wr_op = '0; wr_index = '0;
    wr_part = '0; wr_data = '0; wr_mask = '0; lk_valid = 1'b0; lk_key = '0; lk_intf = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_x1_basic();
    t_priority();
    t_x2();
    t_x4();
    t_miss_write();
    summary();
    $finish;
  end
endmodule